// File: doc/BRIEF.md
# Field Memory Initialization Sequencer

This block brings a serial field memory with independent write and read address pointers into a known state after power-up. It watches a supply-good input. Once that input has been high for a settle interval of at least 100 us, the block runs a fixed sequence on the write side and the read side in the same cycles. Each side gets a burst of dummy memory clock cycles and then a pointer reset. The interval is counted in system clock cycles and derived from a clock frequency parameter. When the sequence ends, a done flag rises and user write and read requests are passed through to the memory clock enables.

A recovery variant is selected with an input. It is meant for the case where clocking of the memory started before the supply had settled. In this variant, each side first gets a pointer reset, then the dummy burst, then a second pointer reset. A memory clock cycle is one system cycle with the matching enable high. A pointer reset strobe is high in exactly one such cycle, together with its clock enable.

Top module: `fmem_init_seq`

## Requirements
- R1: While rst_n is low, and at the first clock after it is released with supply_ok low, every output is 0: both clock enables, both reset strobes, both grants and init_done.
- R2: After supply_ok is first sampled high, there are WAIT_CYC = (CLK_HZ/1000000)*SETTLE_US cycles in which the clock enables and the strobes stay 0.
- R3: In normal mode (recover = 0), the settle interval is followed by exactly DUMMY_CYC cycles in which both wck_en and rck_en are 1 and both strobes are 0.
- R4: Each reset strobe (rstw, rstr) is high for exactly one cycle at a time. It is high only in a cycle where its own clock enable is also high, and the write and read strobes are high in the same cycles.
- R5: init_done rises in the cycle after the final strobe cycle. Before that, user_wr_gnt and user_rd_gnt stay 0 whatever the requests are. Once init_done is high, the grants and the clock enables equal user_wr_req and user_rd_req.
- R6: In recovery mode (recover = 1, sampled at the end of the settle interval), the sequence is one strobe cycle, then DUMMY_CYC dummy cycles, then a second strobe cycle. init_done follows in the next cycle.
- R7: If supply_ok is sampled low at any point, the block is idle in the next cycle with all outputs 0. The whole settle interval is counted again when supply_ok next goes high.
- R8: While init_done is high and supply_ok stays high, init_done stays high and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, high when the supply is stable |
| recover | input | 1 | Selects the reset-burst-reset recovery sequence |
| user_wr_req | input | 1 | User request for a write memory clock cycle |
| user_rd_req | input | 1 | User request for a read memory clock cycle |
| wck_en | output | 1 | Write-side memory clock enable |
| rck_en | output | 1 | Read-side memory clock enable |
| rstw | output | 1 | Write pointer reset strobe |
| rstr | output | 1 | Read pointer reset strobe |
| user_wr_gnt | output | 1 | Write request accepted |
| user_rd_gnt | output | 1 | Read request accepted |
| init_done | output | 1 | Initialization finished |

## Verification
The bench checks the edges of the settle count. A counter off by one would start the clocks one cycle early or late. It checks that the burst has exactly the required number of dummy cycles. A wrong length would leave the pointers unsettled, or would move the strobe and the done flag. The bench toggles user requests during the whole sequence, so that a design leaking grants before done is caught. It drops the supply during the settle interval, during the burst and after done. This exposes a design that resumes a count instead of restarting it. In recovery mode, the bench checks for the leading strobe, which a design that ignored the mode would never issue.

// File: rtl/fmem_init_seq.sv
module fmem_init_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_US = 100,
  parameter int DUMMY_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic recover,
  input  logic user_wr_req,
  input  logic user_rd_req,
  output logic wck_en,
  output logic rck_en,
  output logic rstw,
  output logic rstr,
  output logic user_wr_gnt,
  output logic user_rd_gnt,
  output logic init_done
);

  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int CMAX     = (WAIT_CYC > DUMMY_CYC) ? WAIT_CYC : DUMMY_CYC;
  localparam int CW       = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_PRERST, S_DUMMY, S_RST, S_DONE
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !supply_ok) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_SETTLE;
          cnt   <= '0;
        end
        S_SETTLE:
          if (cnt == CW'(WAIT_CYC - 1)) begin
            cnt   <= '0;
            state <= recover ? S_PRERST : S_DUMMY;
          end else cnt <= cnt + 1'b1;
        S_PRERST: begin
          state <= S_DUMMY;
          cnt   <= '0;
        end
        S_DUMMY:
          if (cnt == CW'(DUMMY_CYC - 1)) begin
            cnt   <= '0;
            state <= S_RST;
          end else cnt <= cnt + 1'b1;
        S_RST:   state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end

  logic seq_clk, strobe;
  assign seq_clk     = (state == S_PRERST) || (state == S_DUMMY) || (state == S_RST);
  assign strobe      = (state == S_PRERST) || (state == S_RST);
  assign init_done   = (state == S_DONE);
  assign user_wr_gnt = init_done & user_wr_req;
  assign user_rd_gnt = init_done & user_rd_req;
  assign wck_en      = seq_clk | user_wr_gnt;
  assign rck_en      = seq_clk | user_rd_gnt;
  assign rstw        = strobe;
  assign rstr        = strobe;

  p_supply_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wck_en && !rck_en && !rstw && !rstr && !init_done);
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rstw || rstr) |=> !rstw && !rstr);
  p_strobe_clocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rstw || rstr) |-> wck_en && rck_en && rstw && rstr);
  p_grant_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (user_wr_gnt || user_rd_gnt) |-> init_done);
  p_done_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(rstw) && $past(rstr));
  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && supply_ok) |=> init_done);
  p_no_strobe_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !rstw && !rstr);

endmodule

// File: tb/fmem_init_seq_bench.sv
module fmem_init_seq_bench;
  localparam int CLK_HZ = 1_000_000;
  localparam int SUS    = 100;
  localparam int NDUM   = 80;
  localparam int W      = (CLK_HZ / 1_000_000) * SUS;

  logic clk = 0, rst_n = 0, supply_ok = 0, recover = 0, wr_req = 0, rd_req = 0;
  logic wck_en, rck_en, rstw, rstr, wr_gnt, rd_gnt, init_done;
  int checks = 0, failures = 0, cyc = 0, t = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fmem_init_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SUS), .DUMMY_CYC(NDUM)) u_fmem_init_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .recover(recover),
    .user_wr_req(wr_req), .user_rd_req(rd_req), .wck_en(wck_en), .rck_en(rck_en),
    .rstw(rstw), .rstr(rstr), .user_wr_gnt(wr_gnt), .user_rd_gnt(rd_gnt),
    .init_done(init_done));

  // reference: t counts consecutive edges with supply good since reset
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || !supply_ok) t <= 0;
    else if (t < W + NDUM + 10) t <= t + 1;
  end

  task automatic compare();
    logic [6:0] exp, act;
    string tag;
    int clk_lo, clk_hi, rst_a, rst_b, done_at;
    bit sclk, sst, dn;
    if (recover) begin
      clk_lo = W + 1; clk_hi = W + NDUM + 2; rst_a = W + 1; rst_b = W + NDUM + 2;
    end else begin
      clk_lo = W + 1; clk_hi = W + NDUM + 1; rst_a = W + NDUM + 1; rst_b = rst_a;
    end
    done_at = rst_b + 1;
    sclk = (t >= clk_lo) && (t <= clk_hi);
    sst  = (t == rst_a) || (t == rst_b);
    dn   = (t >= done_at);
    exp = {sclk | (dn & wr_req), sclk | (dn & rd_req), sst, sst, dn & wr_req, dn & rd_req, dn};
    act = {wck_en, rck_en, rstw, rstr, wr_gnt, rd_gnt, init_done};
    if (!rst_n) tag = "R1";
    else if (t == 0) tag = (cyc < 30) ? "R1" : "R7";
    else if (t <= W) tag = "R2";
    else if (sst) tag = recover ? "R6" : "R4";
    else if (sclk) tag = recover ? "R6" : "R3";
    else tag = (wr_req | rd_req) ? "R5" : "R8";
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0d outputs actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      wr_req = (cyc % 3) == 0;
      rd_req = (cyc % 2) == 1;
    end
  endtask

  initial begin
    step(5);                       // R1 in reset
    rst_n = 1;
    step(10);                      // R1 idle, supply low
    supply_ok = 1;
    step(W + NDUM + 20);           // R2 R3 R4 R5 R8 normal
    supply_ok = 0; step(3);        // R7 drop after done
    supply_ok = 1; step(W / 2);
    supply_ok = 0; step(2);        // R7 drop during settle
    recover = 1;
    supply_ok = 1; step(W + 30);
    supply_ok = 0; step(2);        // R7 drop during dummy burst
    supply_ok = 1; step(W + NDUM + 20); // R6 recovery full run
    rst_n = 0; step(3);            // R1 reset reapplied
    rst_n = 1; recover = 0; step(W + NDUM + 10);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule